// File: doc/BRIEF.md
# Timed Page Load Controller

This block sits on the device side of a byte-wide, page-organised nonvolatile memory. A host sends byte-load strobes, each with an address and a data byte. The controller gathers these bytes into a 128-byte page buffer. A page has no explicit commit command. It stays open while loads keep arriving, and it closes once the load strobe has been quiet for a programmable number of clock cycles. When the page closes, the controller runs an internally timed write cycle. At the end of that cycle it commits the whole page to the array in a single wide write. Columns that received user data take that data. Every other column takes the erased value FFH.

During the write cycle, ordinary reads give no memory data. Each read returns a status byte instead. The host polls this byte to detect the end of the cycle. Bit 7 carries the inverse of the top bit of the most recent loaded byte. Bit 6 changes value on every status read.

All time limits are parameters counted in clock cycles. A simple array model is part of the block, so reads can return committed data.

Top module: `plc_page_ctrl`

## Requirements
- R1: A load address splits into a column (address bits 6..0) and a page number (bits 7 and up). A loaded byte appears after the commit at array location {page, column}.
- R2: A load is accepted only when `ld_stb` has been sampled high on MIN_STROBE consecutive rising edges. A pulse held for fewer edges loads nothing and does not open a page. One pulse gives at most one load.
- R3: The first accepted load opens a page (`page_open` = 1). Each later accepted load restarts the quiet timer, and a load accepted exactly CLOSE_CYC cycles after the previous one still keeps the page open. If no load is accepted for CLOSE_CYC cycles, `page_open` falls and `busy` rises on that edge.
- R4: Loading a column that is already loaded in the open page replaces its buffered byte.
- R5: The page number written is the page number of the last accepted load, whatever the pages of the earlier loads.
- R6: Each commit is one single-cycle `arr_we` pulse that writes all 128 columns. Columns not loaded since the page opened are written as FFH. The loaded mask is cleared when a new page opens.
- R7: `busy` stays high for exactly WRITE_CYC cycles, and `arr_we` is asserted in its last cycle. Load strobes during `busy` are ignored.
- R8: A read accepted while `busy` is high returns, in bit 7, the inverse of bit 7 of the last accepted load.
- R9: While `busy` is high, bit 6 of status reads alternates, starting at 1 for the first status read of each write cycle. Bits 5..0 of a status read are 0.
- R10: After reset, `busy`, `page_open`, `rd_valid` and `arr_we` are 0 and every array byte reads FFH. When not busy, a read returns the array byte at `rd_addr`, with `rd_valid` high exactly one cycle after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Byte-load strobe (level, filtered by width) |
| ld_addr | input | ADDR_W | Load address: column in bits 6..0, page above |
| ld_data | input | 8 | Load data byte |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 8 | Array byte, or status byte while busy |
| page_open | output | 1 | Page load phase active |
| busy | output | 1 | Internal write cycle active |
| arr_we | output | 1 | Single-cycle array page write strobe |
| arr_page | output | ADDR_W-7 | Page number written |
| arr_img | output | 1024 | Page image, column c in bits 8c+7..8c |

## Verification
The page logic is driven with several load patterns:
- scattered loads across one page, which show which columns take user data and which take FFH;
- a reload of the same column, which shows that the newer byte wins;
- a final load to a different page, which shows that the target page follows the last load and not the first.

Two timing patterns test the edges of the strobe filter and the quiet timer:
- a pulse one edge short of the filter width, which must not load;
- a load placed exactly on the quiet-timer limit, which must keep the page open.

During the write cycle, status reads are interleaved with an ignored load. This separates correct polling bits from stale or disturbed buffer state. A second, one-byte page shows that the loaded mask is cleared between pages.

// File: rtl/plc_pkg.sv
`timescale 1ns/1ps
package plc_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_WRITE = 2'd2
    } plc_state_e;

    typedef struct packed {
        logic       inv_msb;
        logic       toggle;
        logic [5:0] zero;
    } plc_status_t;

    function automatic logic [BYTE_W-1:0] fill_byte(input logic loaded,
                                                    input logic [BYTE_W-1:0] d);
        return loaded ? d : ERASED_BYTE;
    endfunction

endpackage

// File: rtl/plc_strobe_filter.sv
`timescale 1ns/1ps
module plc_strobe_filter #(
    parameter int MIN_STROBE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic fire
);
    localparam int CW = $clog2(MIN_STROBE + 1);

    logic [CW-1:0] hi_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q <= '0;
        end else if (!stb) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != CW'(MIN_STROBE)) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign fire = stb && (hi_cnt_q == CW'(MIN_STROBE - 1));

    generate
        if (MIN_STROBE >= 2) begin : g_width_chk
            AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
                fire |-> $past(stb)) else $error("short strobe fired"); // R2
        end
    endgenerate

endmodule

// File: rtl/plc_page_buf.sv
`timescale 1ns/1ps
module plc_page_buf
    import plc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int COLS   = 128
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic                        fresh,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           data,
    output logic [ADDR_W-$clog2(COLS)-1:0] page,
    output logic                        last_msb,
    output logic [COLS-1:0][BYTE_W-1:0] page_img
);
    localparam int COL_W = $clog2(COLS);
    localparam int PG_W  = ADDR_W - COL_W;
    localparam logic [COLS-1:0] ONE_COL = COLS'(1);

    logic [COLS-1:0][BYTE_W-1:0] data_q;
    logic [COLS-1:0]             mask_q;
    logic [PG_W-1:0]             page_q;
    logic                        msb_q;
    logic [COL_W-1:0]            col;

    assign col = addr[COL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mask_q <= '0;
            page_q <= '0;
            msb_q  <= 1'b0;
        end else if (wr) begin
            data_q[col] <= data;
            mask_q      <= (fresh ? '0 : mask_q) | (ONE_COL << col);
            page_q      <= addr[ADDR_W-1:COL_W];
            msb_q       <= data[BYTE_W-1];
        end
    end

    generate
        for (genvar g = 0; g < COLS; g++) begin : g_fill
            assign page_img[g] = fill_byte(mask_q[g], data_q[g]);
        end
    endgenerate

    assign page     = page_q;
    assign last_msb = msb_q;

    AST_IMG_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
        wr |=> page_img[$past(col)] == $past(data)) else $error("column not updated"); // R4

endmodule

// File: rtl/plc_array.sv
`timescale 1ns/1ps
module plc_array
    import plc_pkg::*;
#(
    parameter int COL_W = 7,
    parameter int PG_W  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 we,
    input  logic [PG_W-1:0]                      wpage,
    input  logic [(1<<COL_W)-1:0][BYTE_W-1:0]    wimg,
    input  logic [PG_W+COL_W-1:0]                raddr,
    output logic [BYTE_W-1:0]                    rdata
);
    localparam int COLS  = 1 << COL_W;
    localparam int PAGES = 1 << PG_W;

    logic [PAGES-1:0][COLS-1:0][BYTE_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '1;
        end else if (we) begin
            mem_q[wpage] <= wimg;
        end
    end

    assign rdata = mem_q[raddr[PG_W+COL_W-1:COL_W]][raddr[COL_W-1:0]];

endmodule

// File: rtl/plc_page_ctrl.sv
`timescale 1ns/1ps
module plc_page_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int COLS       = 128,
    parameter int MIN_STROBE = 3,
    parameter int CLOSE_CYC  = 40,
    parameter int WRITE_CYC  = 120
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ld_stb,
    input  logic [ADDR_W-1:0]               ld_addr,
    input  logic [7:0]                      ld_data,
    input  logic                            rd_req,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic                            rd_valid,
    output logic [7:0]                      rd_data,
    output logic                            page_open,
    output logic                            busy,
    output logic                            arr_we,
    output logic [ADDR_W-$clog2(COLS)-1:0]  arr_page,
    output logic [COLS*8-1:0]               arr_img
);
    localparam int COL_W = $clog2(COLS);
    localparam int PG_W  = ADDR_W - COL_W;
    localparam int GW    = $clog2(CLOSE_CYC + 1);
    localparam int WW    = $clog2(WRITE_CYC + 1);

    plc_state_e                   st_q;
    logic [GW-1:0]                gap_q;
    logic [WW-1:0]                wcnt_q;
    logic                         tog_q;
    logic                         ld_fire;
    logic                         buf_wr;
    logic                         close_now;
    logic [PG_W-1:0]              buf_page;
    logic                         buf_msb;
    logic [COLS-1:0][BYTE_W-1:0]  buf_img;
    logic [BYTE_W-1:0]            arr_rdata;
    plc_status_t                  status;

    plc_strobe_filter #(.MIN_STROBE(MIN_STROBE)) u_filter (
        .clk  (clk),
        .rst  (rst),
        .stb  (ld_stb),
        .fire (ld_fire)
    );

    assign buf_wr    = ld_fire && (st_q != ST_WRITE);
    assign close_now = (st_q == ST_LOAD) && !ld_fire && (gap_q == GW'(CLOSE_CYC - 1));
    assign arr_we    = (st_q == ST_WRITE) && (wcnt_q == WW'(WRITE_CYC - 1));

    plc_page_buf #(.ADDR_W(ADDR_W), .COLS(COLS)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr       (buf_wr),
        .fresh    (st_q == ST_IDLE),
        .addr     (ld_addr),
        .data     (ld_data),
        .page     (buf_page),
        .last_msb (buf_msb),
        .page_img (buf_img)
    );

    plc_array #(.COL_W(COL_W), .PG_W(PG_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .wpage (buf_page),
        .wimg  (buf_img),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            gap_q  <= '0;
            wcnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (ld_fire) begin
                        st_q  <= ST_LOAD;
                        gap_q <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ld_fire) begin
                        gap_q <= '0;
                    end else if (close_now) begin
                        st_q   <= ST_WRITE;
                        wcnt_q <= '0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (arr_we) begin
                        st_q <= ST_IDLE;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b1;
        end else if (close_now) begin
            tog_q <= 1'b1;
        end else if ((st_q == ST_WRITE) && rd_req) begin
            tog_q <= ~tog_q;
        end
    end

    assign status = '{inv_msb: ~buf_msb, toggle: tog_q, zero: 6'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= (st_q == ST_WRITE) ? status : arr_rdata;
            end
        end
    end

    assign page_open = (st_q == ST_LOAD);
    assign busy      = (st_q == ST_WRITE);
    assign arr_page  = buf_page;
    assign arr_img   = buf_img;

    AST_CLOSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(page_open)) else $error("busy without open page"); // R3
    AST_LOAD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (page_open && ld_fire) |=> page_open) else $error("page closed on load"); // R3
    AST_WE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !busy) else $error("busy after commit"); // R7
    AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(buf_page) && $stable(buf_msb))) else $error("buffer moved while busy"); // R7
    AST_STATUS_MSB: assert property (@(posedge clk) disable iff (rst)
        (rd_req && busy) |=> (rd_data[7] != $past(buf_msb))) else $error("bad polling bit"); // R8
    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (rd_req && busy && $past(rd_req && busy)) |=> (rd_data[6] != $past(rd_data[6])))
        else $error("toggle bit stuck"); // R9

endmodule

// File: tb/plc_page_ctrl_tb.sv
`timescale 1ns/1ps
module plc_page_ctrl_tb;
    localparam int ADDR_W = 9;
    localparam int COLS   = 128;
    localparam int MIN    = 3;
    localparam int CLOSE  = 40;
    localparam int WRITE  = 120;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ld_stb = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [7:0]       ld_data = '0;
    logic             rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic             page_open;
    logic             busy;
    logic             arr_we;
    logic [1:0]       arr_page;
    logic [COLS*8-1:0] arr_img;

    plc_page_ctrl #(
        .ADDR_W(ADDR_W), .COLS(COLS), .MIN_STROBE(MIN),
        .CLOSE_CYC(CLOSE), .WRITE_CYC(WRITE)
    ) u_dut (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .page_open(page_open), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
        .arr_img(arr_img)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    logic [7:0] mem_m [512];
    logic [7:0] bd_m [COLS];
    bit         bm_m [COLS];
    int         bpg_m = 0;
    logic [7:0] blast_m = 8'h00;
    bit         open_m = 0;
    bit         busy_m = 0;
    bit         tog_m = 1;
    int         c0 = 0;
    int         we_cnt = 0;
    int         we_page = -1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as read results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read data", rd_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                chk(rd_data == e, r, rd_data, e);
            end
        end
        if (!rst && arr_we) begin
            we_cnt++;
            we_page = arr_page;
        end
    end

    task automatic load(input int a, input int d, input int w);
        @(negedge clk);
        ld_stb  = 1'b1;
        ld_addr = a[ADDR_W-1:0];
        ld_data = d[7:0];
        repeat (w) @(posedge clk);
        @(negedge clk);
        ld_stb = 1'b0;
        if (w >= MIN && !busy_m) begin
            if (!open_m) begin
                for (int c = 0; c < COLS; c++) bm_m[c] = 0;
            end
            bm_m[a % COLS] = 1;
            bd_m[a % COLS] = d[7:0];
            bpg_m   = a / COLS;
            blast_m = d[7:0];
            open_m  = 1;
        end
        @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [7:0] e, input string rq);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a[ADDR_W-1:0];
        exp_q.push_back(e);
        req_q.push_back(rq);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid == 1'b1, "R10 rd_valid one cycle after request", rd_valid, 1);
    endtask

    task automatic status_read(input string rq);
        automatic logic [7:0] e = {~blast_m[7], tog_m, 6'b0};
        tog_m = ~tog_m;
        rd(0, e, rq);
    endtask

    // Called right after a load of width MIN: its accept edge is 1.5 cycles back
    task automatic wait_close();
        repeat (CLOSE - 2) @(negedge clk);
        chk(busy == 1'b0 && page_open == 1'b1, "R3 page still open before limit",
            {busy, page_open}, 2'b01);
        @(negedge clk);
        chk(busy == 1'b1 && page_open == 1'b0, "R3 busy at quiet limit",
            {busy, page_open}, 2'b10);
        c0 = cyc;
        busy_m = 1;
        tog_m = 1;
        open_m = 0;
    endtask

    task automatic finish_write();
        automatic int we0 = we_cnt;
        while (cyc < c0 + WRITE - 1) @(negedge clk);
        chk(busy == 1'b1, "R7 busy through last write cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy drops after WRITE_CYC", busy, 0);
        chk(we_cnt == we0 + 1, "R6 single commit pulse", we_cnt - we0, 1);
        chk(we_page == bpg_m, "R5 committed page", we_page, bpg_m);
        for (int c = 0; c < COLS; c++)
            mem_m[bpg_m * COLS + c] = bm_m[c] ? bd_m[c] : 8'hFF;
        busy_m = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        for (int c = 0; c < COLS; c++) begin bm_m[c] = 0; bd_m[c] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk({busy, page_open, rd_valid, arr_we} == 4'b0, "R10 reset outputs",
            {busy, page_open, rd_valid, arr_we}, 0);
        rd(0, 8'hFF, "R10 erased after reset");
        rd(300, 8'hFF, "R10 erased after reset");

        // R2: short pulse in idle must not open a page
        load(5, 8'h11, MIN - 1);
        chk(page_open == 1'b0, "R2 short pulse ignored", page_open, 0);

        // R3 boundary: next load accepted exactly CLOSE cycles later
        load(128 + 3, 8'hA1, MIN);
        repeat (CLOSE - 2 - MIN) @(negedge clk);
        load(128 + 10, 8'hB2, MIN);
        chk(page_open == 1'b1 && busy == 1'b0, "R3 load on the limit keeps page open",
            {busy, page_open}, 2'b01);
        load(128 + 3, 8'hC3, MIN + 2);       // R4 overwrite, long pulse
        load(128 + 20, 8'h99, MIN - 1);      // R2 glitch inside page
        load(128 + 127, 8'h5E, MIN + 1);
        load(256 + 0, 8'h80, MIN);           // R5 last load moves to page 2
        wait_close();
        status_read("R9 first status read");
        status_read("R8 status polling");
        load(1, 8'h77, MIN);                 // R7 ignored while busy
        status_read("R8 status after ignored load");
        finish_write();
        rd(256 + 0, 8'h80, "R1 last load location");
        rd(256 + 3, 8'hC3, "R4 reloaded column");
        rd(256 + 10, 8'hB2, "R5 earlier loads go to last page");
        rd(256 + 20, 8'hFF, "R2 glitch column not loaded");
        rd(256 + 127, 8'h5E, "R1 top column");
        rd(256 + 50, 8'hFF, "R6 unloaded column is FF");
        rd(128 + 3, 8'hFF, "R5 first page untouched");
        rd(1, 8'hFF, "R7 load during busy ignored");
        rd(5, 8'hFF, "R2 idle glitch not stored");

        // Second page on the same page number: mask must restart
        load(256 + 10, 8'h12, MIN);
        wait_close();
        status_read("R9 toggle restarts at 1");
        status_read("R8 inverted msb of 12h");
        finish_write();
        rd(256 + 10, 8'h12, "R1 single byte page");
        rd(256 + 3, 8'hFF, "R6 mask cleared between pages");
        rd(256 + 0, 8'hFF, "R6 mask cleared between pages");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule